// File: doc/BRIEF.md
# Flash and Torch LED Driver Mode Sequencer

This block is the top-level sequencer of a flash/torch LED driver built around a storage capacitor charger. It reads the mode request bits held in a register block: flash, charge, torch, charge-level select, the flash gate override, and the torch and flash level codes. It also takes a one-cycle hardware trigger from strobe logic. From these it chooses one of five operating states. It produces the active-low end-of-charge flag from digitized capacitor comparator results. It shapes the torch level code while charging, and it derates or blocks a flash according to a 6-bit ambient sense code compared against two programmable thresholds.

When a flash finishes, the sequencer issues single-cycle clear pulses that the register block applies at the same clock edge as the state change. These pulses clear the software flash and torch bits, and they clear the torch level MSB when the capacitor droops below target while charging with the torch on. The analog comparators, the charge pump, the flash duration timer and the current DACs sit outside this block. Their results arrive as single-bit inputs and codes.

Top module: `flashModeSeq`

## Requirements
- R1: The state output encodes off=0, torch=1, charge=2, charge+torch=3, flash=4. A request for flash has priority over the other bits. Otherwise the {charge, torch} bits select 00→off, 01→torch, 10→charge, 11→charge+torch. Each state appears one clock after its request.
- R2: With the gate override at 0, a flash starts only while eocN is low. With the override at 1, a flash starts on request whatever eocN is.
- R3: A flash that was requested through the software flash bit asserts clrFlash and clrTorch during its final cycle (flashDone high). A flash started by the hardware trigger asserts neither.
- R4: When flashDone ends a flash, the next state is decoded from the charge and torch bits. Torch is masked if R3 cleared it. If the charge select was 00 (optimal) when the flash started, charging is suppressed until the charge bit falls or the charge select leaves 00.
- R5: eocN is low only in charge or charge+torch while the selected level comparator is high: capAtOptimal for select 00, capAtFixed for 01/10/11. It is high in every other state, including torch-only.
- R6: torchOn is high only in torch or charge+torch while capAboveMin is high. In charge+torch the torch code is 000 until the level comparator is high, then it equals torchLevel.
- R7: In charge+torch, once the target has been reached, a later loss of the level comparator while torchLevel[2]=1 asserts clrT2.
- R8: With sensing enabled and valid thresholds, a sense code ≤ low threshold gives the full flash code. A code above low and ≤ high caps the flash code at 100. A code above high blocks flash entry.
- R9: If senseHigh is not greater than senseLow, or sensing is disabled, the sense code has no effect on the flash.
- R10: The ambient region is sampled when the flash starts and held for the whole pulse.
- R11: After reset the state is off, eocN is high, and torchOn, flashOn and all clear pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqFlash | input | 1 | Software flash bit |
| reqCharge | input | 1 | Charge bit |
| reqTorch | input | 1 | Torch bit |
| hwTrig | input | 1 | One-cycle hardware flash trigger |
| chgSel | input | 2 | Charge level select, 00 = optimal |
| gateOvr | input | 1 | Allow flash without end-of-charge |
| flashDone | input | 1 | Flash timer expiry, ends the pulse |
| capAboveMin | input | 1 | Capacitor above torch minimum |
| capAtFixed | input | 1 | Capacitor at 95% of fixed target |
| capAtOptimal | input | 1 | Capacitor at optimal target |
| senseEn | input | 1 | Ambient sensing enable |
| senseCode | input | 6 | Digitized ambient sense value |
| senseHigh | input | 6 | Upper sense threshold |
| senseLow | input | 6 | Lower sense threshold |
| torchLevel | input | 3 | Programmed torch level |
| flashLevel | input | 3 | Programmed flash level |
| state | output | 3 | Current operating state |
| eocN | output | 1 | End-of-charge flag, active low |
| torchOn | output | 1 | Torch current enable |
| torchCode | output | 3 | Torch level applied |
| flashOn | output | 1 | Flash current enable |
| flashCode | output | 3 | Flash level applied |
| clrFlash | output | 1 | Clear pulse for the flash bit |
| clrTorch | output | 1 | Clear pulse for the torch bit |
| clrT2 | output | 1 | Clear pulse for torch level MSB |

## Verification
The bench builds the block with its default parameters: 6-bit sense codes, 3-bit level codes and a mid-region cap of 4. With 6-bit codes it can set the thresholds at 10 and 40 and drive codes in all three regions. It can also make the thresholds equal, which tests the invalid-threshold rule. The 3-bit levels let it program torch level 7, observe the MSB clear drop it to 3, and program flash levels both above and below the cap. The bench models the register block's clear behaviour, so the post-flash return, the optimal-mode halt and the droop clear are all observed through the state and code outputs.

// File: rtl/flashSeqPkg.sv
package flashSeqPkg;
  typedef enum logic [2:0] {
    MODE_OFF      = 3'd0,
    MODE_TORCH    = 3'd1,
    MODE_CHARGE   = 3'd2,
    MODE_CHGTORCH = 3'd3,
    MODE_FLASH    = 3'd4
  } seqMode_e;

  typedef struct packed {
    logic flashStart;
    logic nextCharging;
    logic inTorchOnly;
    logic inChgTorch;
    logic inFlash;
  } seqStrobes_t;
endpackage

// File: rtl/flashCtrlFsm.sv
module flashCtrlFsm
  import flashSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqFlash,
  input  logic        reqCharge,
  input  logic        reqTorch,
  input  logic        hwTrig,
  input  logic [1:0]  chgSel,
  input  logic        gateOvr,
  input  logic        flashDone,
  input  logic        eocN,
  input  logic        blockFlash,
  output seqMode_e    curState,
  output seqStrobes_t strb,
  output logic        clrFlash,
  output logic        clrTorch
);
  seqMode_e stQ, stNext;
  logic haltQ, swFlashQ, optAtStartQ;
  logic optimalSel, effCharge, flashReq, flashOk, endNow;
  logic postCharge, postTorch;

  function automatic seqMode_e decodeMode(input logic c, input logic t);
    case ({c, t})
      2'b01:   return MODE_TORCH;
      2'b10:   return MODE_CHARGE;
      2'b11:   return MODE_CHGTORCH;
      default: return MODE_OFF;
    endcase
  endfunction

  assign optimalSel = (chgSel == 2'b00);
  assign effCharge  = reqCharge && !(haltQ && optimalSel);
  assign flashReq   = reqFlash || hwTrig;
  assign flashOk    = (gateOvr || !eocN) && !blockFlash;
  assign endNow     = (stQ == MODE_FLASH) && flashDone;
  assign postCharge = effCharge && !optAtStartQ;
  assign postTorch  = reqTorch && !swFlashQ;

  always_comb begin
    if (stQ == MODE_FLASH)
      stNext = flashDone ? decodeMode(postCharge, postTorch) : MODE_FLASH;
    else if (flashReq && flashOk)
      stNext = MODE_FLASH;
    else
      stNext = decodeMode(effCharge, reqTorch);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stQ         <= MODE_OFF;
      haltQ       <= 1'b0;
      swFlashQ    <= 1'b0;
      optAtStartQ <= 1'b0;
    end else begin
      stQ <= stNext;
      if (strb.flashStart) begin
        swFlashQ    <= reqFlash;
        optAtStartQ <= optimalSel;
      end
      if (endNow && optAtStartQ)
        haltQ <= 1'b1;
      else if (!reqCharge || !optimalSel)
        haltQ <= 1'b0;
    end
  end

  assign curState          = stQ;
  assign strb.flashStart   = (stQ != MODE_FLASH) && (stNext == MODE_FLASH);
  assign strb.nextCharging = (stNext == MODE_CHARGE) || (stNext == MODE_CHGTORCH);
  assign strb.inTorchOnly  = (stQ == MODE_TORCH);
  assign strb.inChgTorch   = (stQ == MODE_CHGTORCH);
  assign strb.inFlash      = (stQ == MODE_FLASH);
  assign clrFlash          = endNow && swFlashQ;
  assign clrTorch          = endNow && swFlashQ;

  // R2: without override, no flash entry while end-of-charge is not flagged
  assert_gate_eoc_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stQ != MODE_FLASH && !gateOvr && eocN) |=> (stQ != MODE_FLASH));
  // R8: a blocking ambient region keeps the flash off
  assert_ambient_block_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stQ != MODE_FLASH && blockFlash) |=> (stQ != MODE_FLASH));
  // R3: clear pulses only leave the flash state
  assert_clear_in_flash_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clrFlash || clrTorch) |=> (stQ != MODE_FLASH));
  // R4: an optimal-mode flash never returns straight to charging
  assert_optimal_halt_R4: assert property (@(posedge clk) disable iff (!rstN)
    (endNow && optAtStartQ) |=> (stQ == MODE_OFF || stQ == MODE_TORCH));
endmodule

// File: rtl/flashDatapath.sv
module flashDatapath
  import flashSeqPkg::*;
#(
  parameter int SENSE_W = 6,
  parameter int LEVEL_W = 3,
  parameter int MID_CAP = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobes_t        strb,
  input  logic [1:0]         chgSel,
  input  logic               capAboveMin,
  input  logic               capAtFixed,
  input  logic               capAtOptimal,
  input  logic               senseEn,
  input  logic [SENSE_W-1:0] senseCode,
  input  logic [SENSE_W-1:0] senseHigh,
  input  logic [SENSE_W-1:0] senseLow,
  input  logic [LEVEL_W-1:0] torchLevel,
  input  logic [LEVEL_W-1:0] flashLevel,
  output logic               eocN,
  output logic               blockFlash,
  output logic               torchOn,
  output logic [LEVEL_W-1:0] torchCode,
  output logic               flashOn,
  output logic [LEVEL_W-1:0] flashCode,
  output logic               clrT2
);
  localparam logic [LEVEL_W-1:0] CAP_CODE = LEVEL_W'(MID_CAP);
  localparam int                 MSB      = LEVEL_W - 1;

  logic levelReached, threshOk, regHigh, regMid;
  logic eocNQ, midQ, seenQ;

  assign levelReached = (chgSel == 2'b00) ? capAtOptimal : capAtFixed;
  assign threshOk     = senseEn && (senseHigh > senseLow);
  assign regHigh      = threshOk && (senseCode > senseHigh);
  assign regMid       = threshOk && (senseCode > senseLow) && !regHigh;
  assign blockFlash   = regHigh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eocNQ <= 1'b1;
      midQ  <= 1'b0;
      seenQ <= 1'b0;
    end else begin
      eocNQ <= !(strb.nextCharging && levelReached);
      if (strb.flashStart) midQ <= regMid;
      if (!strb.inChgTorch) seenQ <= 1'b0;
      else if (levelReached) seenQ <= 1'b1;
    end
  end

  assign eocN    = eocNQ;
  assign torchOn = (strb.inTorchOnly || strb.inChgTorch) && capAboveMin;

  always_comb begin
    if (!torchOn)                          torchCode = '0;
    else if (strb.inChgTorch && !levelReached) torchCode = '0;
    else                                   torchCode = torchLevel;
  end

  assign clrT2   = strb.inChgTorch && seenQ && !levelReached && torchLevel[MSB];
  assign flashOn = strb.inFlash;

  always_comb begin
    if (!strb.inFlash)                       flashCode = '0;
    else if (midQ && (flashLevel > CAP_CODE)) flashCode = CAP_CODE;
    else                                     flashCode = flashLevel;
  end

  // R5: torch-only always reports not charged
  assert_eoc_torch_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.inTorchOnly |-> eocN);
  // R6: torch current never enabled below the minimum capacitor level
  assert_torch_min_R6: assert property (@(posedge clk) disable iff (!rstN)
    torchOn |-> capAboveMin);
  // R7: the MSB clear only fires on a droop below target
  assert_t2_droop_R7: assert property (@(posedge clk) disable iff (!rstN)
    clrT2 |-> (!levelReached && strb.inChgTorch));
  // R10: a held mid region caps the flash code for the whole pulse
  assert_mid_cap_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.inFlash && $past(strb.inFlash) && midQ) |-> (flashCode <= CAP_CODE));
endmodule

// File: rtl/flashModeSeq.sv
module flashModeSeq
  import flashSeqPkg::*;
#(
  parameter int SENSE_W = 6,
  parameter int LEVEL_W = 3,
  parameter int MID_CAP = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqFlash,
  input  logic               reqCharge,
  input  logic               reqTorch,
  input  logic               hwTrig,
  input  logic [1:0]         chgSel,
  input  logic               gateOvr,
  input  logic               flashDone,
  input  logic               capAboveMin,
  input  logic               capAtFixed,
  input  logic               capAtOptimal,
  input  logic               senseEn,
  input  logic [SENSE_W-1:0] senseCode,
  input  logic [SENSE_W-1:0] senseHigh,
  input  logic [SENSE_W-1:0] senseLow,
  input  logic [LEVEL_W-1:0] torchLevel,
  input  logic [LEVEL_W-1:0] flashLevel,
  output logic [2:0]         state,
  output logic               eocN,
  output logic               torchOn,
  output logic [LEVEL_W-1:0] torchCode,
  output logic               flashOn,
  output logic [LEVEL_W-1:0] flashCode,
  output logic               clrFlash,
  output logic               clrTorch,
  output logic               clrT2
);
  seqMode_e    curState;
  seqStrobes_t strb;
  logic        blockFlash;

  flashCtrlFsm u_ctrl (
    .clk(clk), .rstN(rstN), .reqFlash(reqFlash), .reqCharge(reqCharge),
    .reqTorch(reqTorch), .hwTrig(hwTrig), .chgSel(chgSel), .gateOvr(gateOvr),
    .flashDone(flashDone), .eocN(eocN), .blockFlash(blockFlash),
    .curState(curState), .strb(strb), .clrFlash(clrFlash), .clrTorch(clrTorch)
  );

  flashDatapath #(.SENSE_W(SENSE_W), .LEVEL_W(LEVEL_W), .MID_CAP(MID_CAP)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .chgSel(chgSel),
    .capAboveMin(capAboveMin), .capAtFixed(capAtFixed), .capAtOptimal(capAtOptimal),
    .senseEn(senseEn), .senseCode(senseCode), .senseHigh(senseHigh),
    .senseLow(senseLow), .torchLevel(torchLevel), .flashLevel(flashLevel),
    .eocN(eocN), .blockFlash(blockFlash), .torchOn(torchOn), .torchCode(torchCode),
    .flashOn(flashOn), .flashCode(flashCode), .clrT2(clrT2)
  );

  assign state = curState;
endmodule

// File: tb/sim_flashModeSeq.sv
`timescale 1ns/1ps
module sim_flashModeSeq;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rFlash = 0, rCharge = 0, rTorch = 0, hwTrig = 0;
  logic [1:0] chgSel = 2'b01;
  logic gateOvr = 0, flashDone = 0;
  logic capAboveMin = 0, capAtFixed = 0, capAtOptimal = 0;
  logic senseEn = 0;
  logic [5:0] senseCode = 0, senseHigh = 6'd40, senseLow = 6'd10;
  logic [2:0] rTorchLvl = 3'd5, flashLevel = 3'd7;
  logic [2:0] state, torchCode, flashCode;
  logic eocN, torchOn, flashOn, clrFlash, clrTorch, clrT2;
  int nChecks = 0, nFails = 0, cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flashModeSeq u0 (
    .clk(clk), .rstN(rstN), .reqFlash(rFlash), .reqCharge(rCharge), .reqTorch(rTorch),
    .hwTrig(hwTrig), .chgSel(chgSel), .gateOvr(gateOvr), .flashDone(flashDone),
    .capAboveMin(capAboveMin), .capAtFixed(capAtFixed), .capAtOptimal(capAtOptimal),
    .senseEn(senseEn), .senseCode(senseCode), .senseHigh(senseHigh), .senseLow(senseLow),
    .torchLevel(rTorchLvl), .flashLevel(flashLevel), .state(state), .eocN(eocN),
    .torchOn(torchOn), .torchCode(torchCode), .flashOn(flashOn), .flashCode(flashCode),
    .clrFlash(clrFlash), .clrTorch(clrTorch), .clrT2(clrT2)
  );

  // register-block model: clears land on the same edge the sequencer moves
  always @(posedge clk) begin
    if (clrFlash) rFlash <= 1'b0;
    if (clrTorch) rTorch <= 1'b0;
    if (clrT2)    rTorchLvl[2] <= 1'b0;
  end

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic endFlash();
    flashDone = 1; step(); flashDone = 0;
  endtask

  task automatic t_reset();
    check("R11 state", state, 0);
    check("R11 eocN", eocN, 1);
    check("R11 torchOn", torchOn, 0);
    check("R11 flashOn", flashOn, 0);
    check("R11 clears", {clrFlash, clrTorch, clrT2}, 0);
  endtask

  task automatic t_decode();
    gateOvr = 1; capAboveMin = 1;
    rTorch = 1; step(); check("R1 torch", state, 1);
    rCharge = 1; step(); check("R1 charge+torch", state, 3);
    rTorch = 0; step(); check("R1 charge", state, 2);
    rTorch = 1; hwTrig = 1; step(); hwTrig = 0;
    check("R1 flash priority", state, 4);
    check("R2 override allows flash", flashOn, 1);
    flashDone = 1; #1;
    check("R3 hw flash no clrTorch", clrTorch, 0);
    step(); flashDone = 0;
    check("R4 return to charge+torch", state, 3);
    rCharge = 0; rTorch = 0; step(); check("R1 off", state, 0);
    gateOvr = 0;
  endtask

  task automatic t_gate();
    chgSel = 2'b01; rCharge = 1; capAtFixed = 0; rFlash = 1;
    step(3);
    check("R2 gated flash held off", state, 2);
    check("R5 eocN below target", eocN, 1);
    capAtFixed = 1; step();
    check("R5 eocN at fixed target", eocN, 0);
    check("R2 not yet flashing", state, 2);
    step(); check("R2 flash after eoc", state, 4);
    flashDone = 1; #1;
    check("R3 clrFlash at end", clrFlash, 1);
    check("R3 clrTorch at end", clrTorch, 1);
    step(); flashDone = 0;
    check("R3 flash bit cleared", rFlash, 0);
    check("R4 back to fixed charge", state, 2);
    rCharge = 0; capAtFixed = 0; step();
  endtask

  task automatic t_optimal();
    chgSel = 2'b00; rCharge = 1; capAtOptimal = 1; capAtFixed = 0;
    step(); check("R5 eocN optimal target", eocN, 0);
    rFlash = 1; step(); check("R4 optimal flash", state, 4);
    endFlash(); check("R4 optimal halts charging", state, 0);
    step(2); check("R4 halt persists", state, 0);
    chgSel = 2'b10; capAtFixed = 1; step();
    check("R4 halt released by new select", state, 2);
    rCharge = 0; capAtOptimal = 0; capAtFixed = 0; step();
  endtask

  task automatic t_torch();
    chgSel = 2'b01; capAtFixed = 1; rTorch = 1; step();
    check("R5 torch-only eocN high", eocN, 1);
    rTorch = 0; step();
    chgSel = 2'b10; rTorchLvl = 3'd7; rCharge = 1; rTorch = 1;
    capAboveMin = 0; capAtFixed = 0; step();
    check("R6 torch off below min", torchOn, 0);
    capAboveMin = 1; #1;
    check("R6 torch on above min", torchOn, 1);
    check("R6 lowest code before target", torchCode, 0);
    capAtFixed = 1; #1;
    check("R6 programmed code at target", torchCode, 7);
    step();
    capAtFixed = 0; #1;
    check("R7 clrT2 on droop", clrT2, 1);
    step();
    check("R7 MSB cleared", rTorchLvl, 3);
    check("R7 single clear", clrT2, 0);
    capAtFixed = 1; #1;
    check("R6 reduced level applies", torchCode, 3);
    rCharge = 0; rTorch = 0; capAtFixed = 0; step();
  endtask

  task automatic t_ambient();
    gateOvr = 1; senseEn = 1; senseLow = 10; senseHigh = 40;
    chgSel = 2'b01; rCharge = 1; flashLevel = 7;
    senseCode = 5; hwTrig = 1; step(); hwTrig = 0;
    check("R8 low region full code", flashCode, 7);
    endFlash();
    senseCode = 25; hwTrig = 1; step(); hwTrig = 0;
    check("R8 mid region capped", flashCode, 4);
    senseCode = 50; step();
    check("R10 region held in pulse", flashCode, 4);
    check("R10 flash continues", state, 4);
    endFlash();
    senseCode = 25; flashLevel = 2; hwTrig = 1; step(); hwTrig = 0;
    check("R8 mid below cap unchanged", flashCode, 2);
    endFlash(); flashLevel = 7;
    senseCode = 50; rFlash = 1; step(3);
    check("R8 high region blocks", state, 2);
    rFlash = 0;
    senseHigh = 10; hwTrig = 1; step(); hwTrig = 0;
    check("R9 bad thresholds ignored", flashCode, 7);
    endFlash();
    senseHigh = 40; senseEn = 0; hwTrig = 1; step(); hwTrig = 0;
    check("R9 disabled sensing ignored", flashOn, 1);
    endFlash();
    rCharge = 0; step();
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    step(3);
    rstN = 1;
    step();
    t_reset();
    t_decode();
    t_gate();
    t_optimal();
    t_torch();
    t_ambient();
    finish();
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      finish();
    end
  end
endmodule